// File: doc/BRIEF.md
# Interleaved SAR Conversion Sequencer

This block produces the timing for a time-interleaved converter built from eight successive-approximation sections that share one input clock. A single phase counter walks a 16-slot schedule. Each section sees that schedule delayed by twice its index, so on every other clock exactly one section takes a new input sample. The aggregate sample rate is therefore half the clock rate.

Every section works through a fixed sequence. It first samples the zero reference, then runs an offset comparison and a gain comparison, then samples the input. Eleven slots of bit-by-bit successive approximation follow, most significant bit first, and one slot hands the result over. Each section has its own 11-bit approximation register and its own single-bit comparator input from the analog side. The analog actions appear only as one-hot strobes per section. A result multiplexer presents the word of whichever section is in its hand-over slot, together with a valid pulse and the section index.

Time `t` counts clocks from 0 at the first schedule slot after reset. Section `k` is in local slot `s = (t - 2k) mod 16`.

Top module: `ilv_sar_sequencer`

## Requirements
- R1: While `rst_n` is low (sampled on the rising edge) and in the first cycle after it is seen high, every strobe and `res_valid` are 0. The following cycle is t=0, in which `refz_stb[0]` is 1.
- R2: Section k runs a 16-slot schedule that repeats without end. Slot 0 asserts `refz_stb[k]`, slot 1 `az_stb[k]`, slot 2 `cal_stb[k]`, slot 3 `smp_stb[k]`, slots 4 to 14 approximate and slot 15 transfers. No strobe of section k is set in any other slot.
- R3: In every active cycle at most one bit of `smp_stb` is set. It is set exactly in the cycles with odd t, which gives a sample rate of half the clock.
- R4: In slot 4+i (i = 0..10), section k resolves result bit 10-i to the value of `cmp_in[k]` sampled at the rising edge that ends that slot (1 keeps the trial bit, 0 clears it).
- R5: `cmp_in[k]` has no effect on section k's result outside that section's slots 4 to 14.
- R6: In a section's slot 15, if R7 allows it, `res_valid` is 1, `res_sect` is the section index and `res_data` is its result. In every other cycle `res_valid`, `res_sect` and `res_data` are 0.
- R7: A section's slot 15 produces no valid pulse unless that section has passed its slot 3 since reset. A reset in the middle of a run restarts the schedule at t=0 under this rule.
- R8: Once every section has sampled since reset, `res_valid` is 1 in every cycle with odd t and 0 in every cycle with even t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_in | input | 8 | Comparator decision, one bit per section |
| refz_stb | output | 8 | Zero-reference sample strobe per section |
| az_stb | output | 8 | Offset (auto-zero) comparison strobe per section |
| cal_stb | output | 8 | Gain calibration comparison strobe per section |
| smp_stb | output | 8 | Input sample strobe per section |
| res_valid | output | 1 | Result word present this cycle |
| res_sect | output | 3 | Index of the section delivering the result |
| res_data | output | 11 | Result word of the transferring section |

## Verification
On every odd t, one section takes its input sample while the section two indices higher hands its result to the multiplexer. At the same time several other sections are in the middle of their approximation. The bench drives independent comparator bits to all sections in every cycle, including runs that force the bits outside each section's approximation window to all ones or all zeros. At every such cycle it judges the sample strobe, the valid pulse and the word against a model that keeps only the bits from each section's own window. A reset in the middle of a run checks that stale transfers stay silent until each section has sampled again.

// File: rtl/isq_pkg.sv
// Package: shared slot map and sizing helpers for the interleaved sequencer.
// Assumes a schedule of four fixed pre-slots, RES_W approximation slots and
// one transfer slot per section.
package isq_pkg;

    localparam int SLOT_REFZ = 0;
    localparam int SLOT_AZ   = 1;
    localparam int SLOT_CAL  = 2;
    localparam int SLOT_SMP  = 3;
    localparam int SLOT_SAR0 = 4;
    localparam int PRE_SLOTS = 4;

    typedef enum logic [2:0] {
        K_REFZ,
        K_AZ,
        K_CAL,
        K_SMP,
        K_SAR,
        K_XFER
    } slot_kind_e;

    // Schedule length for a given result width.
    function automatic int sched_len(input int res_w);
        return PRE_SLOTS + res_w + 1;
    endfunction

    // Classify a local slot number into the action it performs.
    function automatic slot_kind_e classify(input int slot, input int res_w);
        if (slot == SLOT_REFZ)                    return K_REFZ;
        else if (slot == SLOT_AZ)                 return K_AZ;
        else if (slot == SLOT_CAL)                return K_CAL;
        else if (slot == SLOT_SMP)                return K_SMP;
        else if (slot < PRE_SLOTS + res_w)        return K_SAR;
        else                                      return K_XFER;
    endfunction

endpackage

// File: rtl/isq_phase_gen.sv
// Module: isq_phase_gen
// Shared phase counter. After reset it idles for one cycle (running low),
// then counts 0..N_PHASE-1 and wraps. Assumes a synchronous active-low reset.
module isq_phase_gen #(
    parameter int N_PHASE = 16,
    parameter int PH_W    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            running,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] LAST = PH_W'(N_PHASE - 1);

    // Run flag: rises on the first edge that sees reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= 1'b1;
    end

    // Phase counter: advances only while running, wraps at the schedule end.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (running) begin
            if (phase == LAST)  phase <= '0;
            else                phase <= phase + 1'b1;
        end
    end

    // The counter steps by one each active cycle and wraps to zero.
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && $past(rst_n)) |->
            (($past(phase) == LAST) ? (phase == '0) : (phase == $past(phase) + 1'b1)));

endmodule

// File: rtl/isq_section.sv
// Module: isq_section
// One successive-approximation section. Derives its local slot from the
// shared phase, offset by IDX*STAGGER, decodes the strobes and runs an
// RES_W-bit approximation register fed by its own comparator bit.
// Assumes the phase input counts with wrap at N_PHASE and the comparator
// bit is settled before each rising edge.
module isq_section
    import isq_pkg::*;
#(
    parameter int IDX     = 0,
    parameter int STAGGER = 2,
    parameter int N_PHASE = 16,
    parameter int PH_W    = 4,
    parameter int RES_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [PH_W-1:0]  phase,
    input  logic             cmp,
    output logic             refz,
    output logic             az,
    output logic             cal,
    output logic             smp,
    output logic             xfer,
    output logic [RES_W-1:0] result
);

    localparam int OFFS     = (IDX * STAGGER) % N_PHASE;
    localparam int SAR_LAST = PRE_SLOTS + RES_W - 1;
    localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

    logic [PH_W:0]      slot_sum;
    logic [PH_W-1:0]    slot;
    slot_kind_e         kind;
    logic [RES_W-1:0]   sar;
    logic [RES_W-1:0]   sar_nxt;
    logic               primed;

    // Local slot: shared phase minus this section's offset, modulo N_PHASE.
    always_comb begin
        slot_sum = {1'b0, phase} + (PH_W+1)'(N_PHASE - OFFS);
        if (slot_sum >= (PH_W+1)'(N_PHASE))
            slot_sum = slot_sum - (PH_W+1)'(N_PHASE);
        slot = slot_sum[PH_W-1:0];
        kind = classify(int'(slot), RES_W);
    end

    // Strobe decode, quiet while the sequencer is idle.
    always_comb begin
        refz = running && (kind == K_REFZ);
        az   = running && (kind == K_AZ);
        cal  = running && (kind == K_CAL);
        smp  = running && (kind == K_SMP);
        xfer = running && (kind == K_XFER) && primed;
    end

    // Next approximation word: commit the decided bit, raise the next trial bit.
    always_comb begin
        int bi;
        bi      = SAR_LAST - int'(slot);
        sar_nxt = sar;
        for (int b = 0; b < RES_W; b++) begin
            if (b == bi)     sar_nxt[b] = cmp;
            if (b == bi - 1) sar_nxt[b] = 1'b1;
        end
    end

    // Approximation register and sampled flag, stepping per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar    <= '0;
            primed <= 1'b0;
        end else if (running) begin
            if (kind == K_SMP) begin
                sar    <= MSB_ONE;
                primed <= 1'b1;
            end else if (kind == K_SAR) begin
                sar    <= sar_nxt;
            end
        end
    end

    assign result = sar;

    // The first approximation slot starts from the lone MSB trial bit.
    assert_trial_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && primed && kind == K_SAR && int'(slot) == SLOT_SAR0) |-> (sar == MSB_ONE));

    // Gain comparison follows the offset comparison one cycle later.
    assert_cal_after_az_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cal && $past(running) && $past(rst_n)) |-> $past(az));

    // Input sample follows the gain comparison one cycle later.
    assert_smp_after_cal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && $past(running) && $past(rst_n)) |-> $past(cal));

endmodule

// File: rtl/isq_result_mux.sv
// Module: isq_result_mux
// N-to-1 result selector. Presents the word and index of the section whose
// transfer flag is set; outputs zero otherwise. Assumes at most one section
// transfers per cycle, which the staggered schedule guarantees.
module isq_result_mux #(
    parameter int N_SECT = 8,
    parameter int SEL_W  = 3,
    parameter int RES_W  = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SECT-1:0]       xfer,
    input  logic [N_SECT*RES_W-1:0] res_flat,
    output logic                    valid,
    output logic [SEL_W-1:0]        sect,
    output logic [RES_W-1:0]        data
);

    // AND-OR selection of the transferring section's word and index.
    always_comb begin
        valid = 1'b0;
        sect  = '0;
        data  = '0;
        for (int k = 0; k < N_SECT; k++) begin
            if (xfer[k]) begin
                valid = 1'b1;
                sect  = sect | SEL_W'(k);
                data  = data | res_flat[k*RES_W +: RES_W];
            end
        end
    end

    // Never two sections transferring in the same cycle.
    assert_single_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer));

    // Results arrive at most every other cycle.
    assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(rst_n)) |-> !$past(valid));

endmodule

// File: rtl/ilv_sar_sequencer.sv
// Module: ilv_sar_sequencer (top)
// Sequencer for N_SECT interleaved approximation sections sharing one
// phase counter, each delayed by STAGGER clocks, with a result multiplexer.
// Assumes N_SECT*STAGGER equals the schedule length so the stagger tiles it.
module ilv_sar_sequencer #(
    parameter int N_SECT  = 8,
    parameter int STAGGER = 2,
    parameter int RES_W   = 11
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [N_SECT-1:0]                  cmp_in,
    output logic [N_SECT-1:0]                  refz_stb,
    output logic [N_SECT-1:0]                  az_stb,
    output logic [N_SECT-1:0]                  cal_stb,
    output logic [N_SECT-1:0]                  smp_stb,
    output logic                               res_valid,
    output logic [(N_SECT > 1 ? $clog2(N_SECT) : 1)-1:0] res_sect,
    output logic [RES_W-1:0]                   res_data
);

    localparam int N_PHASE = isq_pkg::sched_len(RES_W);
    localparam int PH_W    = $clog2(N_PHASE);
    localparam int SEL_W   = (N_SECT > 1) ? $clog2(N_SECT) : 1;

    logic                    running;
    logic [PH_W-1:0]         phase;
    logic [N_SECT-1:0]       xfer;
    logic [N_SECT*RES_W-1:0] res_flat;
    logic                    smp_any;

    isq_phase_gen #(
        .N_PHASE (N_PHASE),
        .PH_W    (PH_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .phase   (phase)
    );

    for (genvar k = 0; k < N_SECT; k++) begin : g_sect
        isq_section #(
            .IDX     (k),
            .STAGGER (STAGGER),
            .N_PHASE (N_PHASE),
            .PH_W    (PH_W),
            .RES_W   (RES_W)
        ) u_sect (
            .clk     (clk),
            .rst_n   (rst_n),
            .running (running),
            .phase   (phase),
            .cmp     (cmp_in[k]),
            .refz    (refz_stb[k]),
            .az      (az_stb[k]),
            .cal     (cal_stb[k]),
            .smp     (smp_stb[k]),
            .xfer    (xfer[k]),
            .result  (res_flat[k*RES_W +: RES_W])
        );
    end

    isq_result_mux #(
        .N_SECT (N_SECT),
        .SEL_W  (SEL_W),
        .RES_W  (RES_W)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer     (xfer),
        .res_flat (res_flat),
        .valid    (res_valid),
        .sect     (res_sect),
        .data     (res_data)
    );

    // Any section sampling this cycle.
    assign smp_any = |smp_stb;

    // At most one section samples in any cycle.
    assert_one_sampler_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(smp_stb));

    // Sampling alternates cycle by cycle while active.
    assert_half_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && $past(rst_n)) |-> (smp_any != $past(smp_any)));

endmodule

// File: tb/ilv_sar_sequencer_bench.sv
// Bench: random and directed comparator patterns against a slot model.
module ilv_sar_sequencer_bench;

    localparam int NS = 8;
    localparam int RW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] cmp_in;
    logic [NS-1:0] refz_stb, az_stb, cal_stb, smp_stb;
    logic          res_valid;
    logic [2:0]    res_sect;
    logic [RW-1:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int            t;
    bit            primed [NS];
    logic [RW-1:0] acc    [NS];

    always #4 clk = ~clk;

    ilv_sar_sequencer u_ilv_sar_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_in    (cmp_in),
        .refz_stb  (refz_stb),
        .az_stb    (az_stb),
        .cal_stb   (cal_stb),
        .smp_stb   (smp_stb),
        .res_valid (res_valid),
        .res_sect  (res_sect),
        .res_data  (res_data)
    );

    function automatic int slot_of(int k, int tt);
        return (((tt - 2*k) % 16) + 16) % 16;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%h expected=%h", req, t, act, exp);
        end
    endtask

    // Reset for n cycles, checking quiet outputs, then release.
    task automatic do_reset(int n);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R1", {refz_stb, az_stb, cal_stb, smp_stb, res_valid}, '0);
        end
        rst_n = 1'b1;
        // idle cycle: release seen at next edge, outputs still quiet here
        check("R1", {refz_stb, az_stb, cal_stb, smp_stb, res_valid}, '0);
        for (int k = 0; k < NS; k++) begin
            primed[k] = 0;
            acc[k]    = '0;
        end
        t = 0;
    endtask

    // One active cycle: check outputs, drive comparator bits, update model.
    task automatic step(int mode);
        logic [NS-1:0] e_refz, e_az, e_cal, e_smp;
        logic          e_valid;
        logic [2:0]    e_sect;
        logic [RW-1:0] e_data;
        bit            all_primed;
        int            s;
        @(negedge clk);
        e_refz = '0; e_az = '0; e_cal = '0; e_smp = '0;
        e_valid = 0; e_sect = '0; e_data = '0; all_primed = 1;
        for (int k = 0; k < NS; k++) begin
            s = slot_of(k, t);
            e_refz[k] = (s == 0);
            e_az[k]   = (s == 1);
            e_cal[k]  = (s == 2);
            e_smp[k]  = (s == 3);
            if (!primed[k]) all_primed = 0;
            if (s == 15 && primed[k]) begin
                e_valid = 1;
                e_sect  = 3'(k);
                e_data  = acc[k];
            end
            if (s == 15 && !primed[k])
                check("R7", {31'd0, res_valid}, 32'd0);
        end
        if (t == 0) check("R1", {31'd0, refz_stb[0]}, 32'd1);
        check("R2", {refz_stb, az_stb, cal_stb, smp_stb}, {e_refz, e_az, e_cal, e_smp});
        check("R3", $countones(smp_stb), (t % 2 == 1) ? 1 : 0);
        check("R6", {31'd0, res_valid}, {31'd0, e_valid});
        if (e_valid)
            check(mode >= 4 ? "R5" : "R4", {18'd0, res_sect, res_data}, {18'd0, e_sect, e_data});
        else
            check("R6", {18'd0, res_sect, res_data}, '0);
        if (all_primed) check("R8", {31'd0, res_valid}, (t % 2 == 1) ? 1 : 0);
        // drive comparator bits for the edge ending this cycle
        for (int k = 0; k < NS; k++) begin
            bit in_sar;
            s = slot_of(k, t);
            in_sar = (s >= 4 && s <= 14);
            case (mode)
                1:       cmp_in[k] = 1'b1;
                2:       cmp_in[k] = 1'b0;
                3:       cmp_in[k] = ((t + k) % 2 == 0);
                4:       cmp_in[k] = in_sar ? 1'($urandom) : 1'b1;
                5:       cmp_in[k] = in_sar ? 1'($urandom) : 1'b0;
                default: cmp_in[k] = 1'($urandom);
            endcase
            if (s == 3) begin
                primed[k] = 1;
                acc[k]    = '0;
            end else if (in_sar) begin
                acc[k][14 - s] = cmp_in[k];
            end
        end
        t++;
    endtask

    initial begin
        void'($urandom(32'h5A3C_91E7));
        rst_n  = 1'b0;
        cmp_in = '0;
        t      = 0;
        do_reset(3);
        for (int i = 0; i < 200; i++) step(0);
        for (int i = 0; i < 64;  i++) step(1);
        for (int i = 0; i < 64;  i++) step(2);
        for (int i = 0; i < 64;  i++) step(3);
        for (int i = 0; i < 160; i++) step(4);
        for (int i = 0; i < 160; i++) step(5);
        for (int i = 0; i < 37;  i++) step(0);
        do_reset(2);
        for (int i = 0; i < 200; i++) step(0);
        do_reset(1);
        for (int i = 0; i < 96;  i++) step(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog t=%0d actual=hung expected=done", t);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule